// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns three independent reset causes into one system reset with a fixed timing. The causes are a clock-generator lock flag that has dropped, an external reset pin driven low, and a software reset bit set high. Any one of them pulls the reset output low at once, through the asynchronous clear of every register in the block. No clock edge is needed for this.

Release is slow and deliberate. Once every cause has gone away, a short synchronizer retimes the release into the clock domain. A free-running counter must then complete one full wrap with no cause returning, so a lock flag that bounces never lets reset go early. When the counter wraps, a sticky flag is set. That flag drives a shift-register pipeline. Loads near the block can take reset from an early stage, and distant or high-fanout loads can take it from a later stage that can be registered close to them. The block has no handshake with the logic it resets. A status output shows whether the final stage is still in reset.

Top module: `rst_sequencer`

## Requirements
- R1: The reset request is active while `pll_locked_i` is 0, or `hw_rst_n_i` is 0, or `sw_rst_i` is 1. While the request is active, `rst_n_o` and every bit of `tap_rst_n_o` are 0 and `in_reset_o` is 1. These outputs reach those values within the same clock period as the request, with no clock edge needed.
- R2: Release starts only when all three causes are inactive. Removing some causes while another stays active keeps the outputs in reset for any length of time.
- R3: Count the rising clock edges after the request goes inactive, starting at 1. `rst_n_o` is 0 up to edge `2**CNT_W + SYNC_STAGES + DEPTH - 1` and is 1 from edge `2**CNT_W + SYNC_STAGES + DEPTH` on. This interval is made up of the synchronizer stages, one full counter wrap and the pipeline depth.
- R4: If any cause becomes active again before release, the sequence restarts in full. The release edge in R3 is then counted from the moment the last request goes inactive.
- R5: Tap bit k of `tap_rst_n_o` goes to 1 at edge `2**CNT_W + SYNC_STAGES + TAP_SEL[k]`, counted as in R3. TAP_SEL values lie in 1..DEPTH, and DEPTH is the final stage.
- R6: `in_reset_o` is always the inverse of `rst_n_o`.
- R7: After release, `rst_n_o` and the taps stay at 1 for as long as no cause becomes active again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for release timing and the pipeline |
| pll_locked_i | input | 1 | Lock flag of the clock generator; 0 requests reset |
| hw_rst_n_i | input | 1 | External reset pin, active low |
| sw_rst_i | input | 1 | Software reset request, active high |
| rst_n_o | output | 1 | Final pipeline stage: system reset, active low |
| tap_rst_n_o | output | NUM_TAPS | Active-low reset taken from the pipeline stages chosen by TAP_SEL |
| in_reset_o | output | 1 | 1 while the final stage still holds reset |

## Verification
Each cause is raised on its own in the middle of a clock period. Each one must clear the outputs before the next edge, which shows that assertion is asynchronous for that source. Mixed-cause patterns, where some causes are removed while others stay active, separate the OR of the causes from a single-source path. Random glitches of random length injected at random points of the count, including one just before release, separate a true restart from a counter that merely pauses. Release edges measured on the final stage and on each tap separate the synchronizer, counter and pipeline contributions from one another.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   // Clock edges from request removal until a pipeline stage releases
   function automatic int unsigned release_latency(int unsigned cnt_w,
                                                   int unsigned sync_len,
                                                   int unsigned stage);
      return (32'd1 << cnt_w) + sync_len + stage;
   endfunction

endpackage

// File: rtl/rst_req_combine.sv
module rst_req_combine (
   input  logic pll_locked_i,
   input  logic hw_rst_n_i,
   input  logic sw_rst_i,
   output logic req_o
);
   // R1: any single cause forms the request
   assign req_o = !pll_locked_i || !hw_rst_n_i || sw_rst_i;
endmodule

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   output logic rel_o
);
   logic [STAGES-1:0] sync_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) sync_q <= '0;
      else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
   end

   assign rel_o = sync_q[STAGES-1];

   // Release leaves the synchronizer only after a full pass through it
   assert_sync_order_R3: assert property (@(posedge clk_i) disable iff (!arst_n_i)
      $rose(rel_o) |-> $past(sync_q[STAGES-2]));
endmodule

// File: rtl/rst_release_timer.sv
module rst_release_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic start_i,
   output logic done_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (start_i && !done_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == {CNT_W{1'b1}}) done_q <= 1'b1;
      end
   end

   assign done_o = done_q;

   assert_idle_count_R2: assert property (@(posedge clk_i) disable iff (!arst_n_i)
      !start_i |-> (cnt_q == '0 && !done_q));
   assert_full_wrap_R3: assert property (@(posedge clk_i) disable iff (!arst_n_i)
      $rose(done_q) |-> $past(cnt_q) == {CNT_W{1'b1}});
   assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!arst_n_i)
      done_q |=> done_q);
endmodule

// File: rtl/rst_out_pipe.sv
module rst_out_pipe #(
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned NUM_TAPS = 2,
   parameter int unsigned TAP_SEL [NUM_TAPS] = '{1, 4}
) (
   input  logic                clk_i,
   input  logic                arst_n_i,
   input  logic                done_i,
   output logic                last_o,
   output logic [NUM_TAPS-1:0] taps_o
);
   logic [DEPTH-1:0] stage_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) stage_q <= '0;
      else           stage_q <= {stage_q[DEPTH-2:0], done_i};
   end

   assign last_o = stage_q[DEPTH-1];

   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
      assign taps_o[k] = stage_q[TAP_SEL[k]-1];
   end

   assert_stage0_R5: assert property (@(posedge clk_i) disable iff (!arst_n_i)
      $rose(stage_q[0]) |-> $past(done_i));
   for (genvar s = 1; s < DEPTH; s++) begin : g_chk
      assert_stage_shift_R5: assert property (@(posedge clk_i) disable iff (!arst_n_i)
         $rose(stage_q[s]) |-> $past(stage_q[s-1]));
   end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
   import rst_seq_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned NUM_TAPS    = 2,
   parameter int unsigned TAP_SEL [NUM_TAPS] = '{1, 4}
) (
   input  logic                clk_i,
   input  logic                pll_locked_i,
   input  logic                hw_rst_n_i,
   input  logic                sw_rst_i,
   output logic                rst_n_o,
   output logic [NUM_TAPS-1:0] tap_rst_n_o,
   output logic                in_reset_o
);
   localparam int unsigned RELEASE_EDGES = release_latency(CNT_W, SYNC_STAGES, DEPTH);

   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt
      $error("rst_sequencer: CNT_W must lie in 2..30");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rst_sequencer: SYNC_STAGES must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("rst_sequencer: DEPTH must be at least 2");
   end
   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap_chk
      if (TAP_SEL[k] < 1 || TAP_SEL[k] > DEPTH) begin : g_bad_tap
         $error("rst_sequencer: TAP_SEL entry out of 1..DEPTH");
      end
   end

   logic req;
   logic arst_n;
   logic rel;
   logic done;
   logic last;

   rst_req_combine u_combine (
      .pll_locked_i (pll_locked_i),
      .hw_rst_n_i   (hw_rst_n_i),
      .sw_rst_i     (sw_rst_i),
      .req_o        (req)
   );

   assign arst_n = !req;

   rst_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i    (clk_i),
      .arst_n_i (arst_n),
      .rel_o    (rel)
   );

   rst_release_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i    (clk_i),
      .arst_n_i (arst_n),
      .start_i  (rel),
      .done_o   (done)
   );

   rst_out_pipe #(.DEPTH(DEPTH), .NUM_TAPS(NUM_TAPS), .TAP_SEL(TAP_SEL)) u_pipe (
      .clk_i    (clk_i),
      .arst_n_i (arst_n),
      .done_i   (done),
      .last_o   (last),
      .taps_o   (tap_rst_n_o)
   );

   assign rst_n_o    = last;
   assign in_reset_o = !last;

   // Edge counter used by the release-window checks (saturating)
   logic [31:0] chk_edges_q;
   always_ff @(posedge clk_i or negedge arst_n) begin
      if (!arst_n)                 chk_edges_q <= '0;
      else if (chk_edges_q != '1)  chk_edges_q <= chk_edges_q + 1'b1;
   end

   assert_async_hold_R1: assert property (@(posedge clk_i)
      req |-> (!rst_n_o && tap_rst_n_o == '0));
   assert_early_hold_R3: assert property (@(posedge clk_i) disable iff (req)
      (chk_edges_q < RELEASE_EDGES) |-> !rst_n_o);
   assert_on_time_R3: assert property (@(posedge clk_i) disable iff (req)
      (chk_edges_q >= RELEASE_EDGES) |-> rst_n_o);
   assert_stays_up_R7: assert property (@(posedge clk_i) disable iff (req)
      rst_n_o |=> rst_n_o);
endmodule

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;
   localparam int W  = 8;
   localparam int S  = 2;
   localparam int D  = 4;
   localparam int NT = 2;
   localparam int unsigned TS [NT] = '{1, 3};
   localparam int L  = (1 << W) + S + D;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic pll_locked = 1'b0;
   logic hw_n       = 1'b0;
   logic sw         = 1'b1;
   logic          rst_n;
   logic [NT-1:0] taps;
   logic          in_rst;

   int checks = 0;
   int fails  = 0;

   rst_sequencer #(.CNT_W(W), .SYNC_STAGES(S), .DEPTH(D), .NUM_TAPS(NT), .TAP_SEL(TS))
   u_rst_sequencer (
      .clk_i        (clk),
      .pll_locked_i (pll_locked),
      .hw_rst_n_i   (hw_n),
      .sw_rst_i     (sw),
      .rst_n_o      (rst_n),
      .tap_rst_n_o  (taps),
      .in_reset_o   (in_rst)
   );

   function automatic int exp_rise(int base, int stage);
      return base + (1 << W) + S + stage;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // mask bit0: lock lost, bit1: pin low, bit2: software request
   task automatic drive(int mask);
      pll_locked = !mask[0];
      hw_n       = !mask[1];
      sw         = mask[2];
   endtask

   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic in_reset_check(string req);
      chk(req, {29'd0, rst_n, taps}, 0);
      chk("R6", int'(in_rst), 1);
   endtask

   // Called at a sample point with causes active; clears them and times release
   task automatic run_release(int gsrc, int gat, int glen);
      int base;
      int rise_main;
      int rise_tap [NT];
      logic prev_main;
      logic [NT-1:0] prev_tap;
      int bad_status;
      base = (glen > 0) ? gat + glen : 0;
      rise_main = -1;
      for (int k = 0; k < NT; k++) rise_tap[k] = -1;
      prev_main = rst_n;
      prev_tap  = taps;
      bad_status = 0;
      drive(0);
      for (int n = 1; n <= base + L + 5; n++) begin
         @(posedge clk);
         #1;
         if (rst_n && !prev_main) rise_main = n;
         for (int k = 0; k < NT; k++)
            if (taps[k] && !prev_tap[k]) rise_tap[k] = n;
         if (in_rst !== !rst_n) bad_status++;
         prev_main = rst_n;
         prev_tap  = taps;
         if (glen > 0 && n == gat) begin
            drive(gsrc);
            #1;
            chk("R1 glitch", {29'd0, rst_n, taps}, 0);   // R4 restart begins
            prev_main = rst_n;
            prev_tap  = taps;
         end
         if (glen > 0 && n == gat + glen) drive(0);
      end
      chk(glen > 0 ? "R4" : "R3", rise_main, exp_rise(base, D));
      for (int k = 0; k < NT; k++)
         chk("R5", rise_tap[k], exp_rise(base, int'(TS[k])));
      chk("R6", bad_status, 0);
   endtask

   initial begin
      #1_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int mask;
      void'($urandom(32'd20240611));
      #1;
      in_reset_check("R1 reset state");
      step(3);
      in_reset_check("R1 reset state");

      // Plain release, then stay released (R3, R5, R7)
      run_release(0, 0, 0);
      begin
         int lows = 0;
         for (int i = 0; i < 40; i++) begin
            step(1);
            if (!rst_n || taps != '1 || in_rst) lows++;
         end
         chk("R7", lows, 0);
      end

      // Each cause alone asserts reset before any clock edge (R1)
      for (int b = 0; b < 3; b++) begin
         drive(1 << b);
         #1;
         in_reset_check("R1 single cause");
         step(2);
         run_release(0, 0, 0);
      end

      // Two causes, remove one: still in reset (R2)
      drive(3);
      step(2);
      drive(1);
      step(L + 10);
      in_reset_check("R2 partial removal");
      drive(6);
      step(3);
      drive(4);
      step(L + 10);
      in_reset_check("R2 partial removal");
      run_release(0, 0, 0);

      // Glitch of lock one edge before release (R4)
      drive(2);
      #1;
      in_reset_check("R1 pin");
      step(1);
      run_release(1, L - 1, 1);

      // Random patterns with optional glitches
      for (int t = 0; t < 30; t++) begin
         mask = $urandom_range(1, 7);
         drive(mask);
         #1;
         in_reset_check("R1 random");
         step($urandom_range(1, 20));
         in_reset_check("R2 random hold");
         if ($urandom_range(0, 1) == 1)
            run_release($urandom_range(1, 7), $urandom_range(1, L - 1), $urandom_range(1, 8));
         else
            run_release(0, 0, 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule